// File: doc/BRIEF.md
# Flash Line Buffer with Sequential Prefetch

This block sits between one read port and a slow non-volatile array that delivers 128-bit lines. It keeps four line buffers, each with a line tag and a valid flag. A read whose line is buffered is answered from the buffer one cycle after it is presented. A read that misses launches a line fetch toward the array, and the requester gets its word when the line comes back. A 2-bit prefetch policy sets what else happens. With the policy at zero, fetched lines are never kept. With the policy at one, a missed line is kept. With the upper policy bit set, a buffer hit also fetches the next sequential line in the background.

An enable setting switches buffer service off. While it is off, every valid flag is wiped, so all reads go to the array. The array side takes one line fetch at a time over a request/acknowledge pair. A fetch that comes back flagged as failed is passed to the waiting reader and is never kept. Both settings sit in a small configuration register, which is loaded through a write strobe.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset the prefetch policy is 2'b10 and the enable is 1. rd_ready, rd_err and mem_req are low, and no line is buffered. A cycle with cfg_wr high loads both settings, and they take effect from the next cycle.
- R2: A read address splits into a line number (rd_addr[15:4]) and a word select (rd_addr[3:2]); word w is mem_data[32w+31:32w]. With the policy at 2'b01, a miss fetches that line and keeps it. A later read of the same line is served with no fetch, and rd_ready rises one cycle after the request. Policy 2'b01 never prefetches.
- R3: With the policy at 2'b00, a missed line is fetched and returned but not kept, so reading it again fetches it again.
- R4: With the policy at 2'b10 or 2'b11, a buffer hit fetches line number + 1 (wrapping at 12 bits). It does not do so if that line is already buffered, already being fetched or already queued.
- R5: A hit launches at most one prefetch, and a miss launches none.
- R6: While the enable is 0, no read is served from a buffer and all valid flags are cleared, so lines buffered before it was turned off miss after it is turned back on.
- R7: A fetch acknowledged with mem_err high sets no valid flag. A reader waiting for that line gets rd_err high with its rd_ready pulse.
- R8: A read of a line whose fetch is in progress waits for that fetch and is served from it, with no second fetch.
- R9: A prefetch found while the array is busy is held in a one-entry queue, and a newer one replaces it. A demand fetch is issued before the queued prefetch.
- R10: There are four buffers. A fill takes the lowest-numbered invalid buffer, or otherwise the least recently used one, where hits and fills both count as use.
- R11: mem_req stays high with mem_addr unchanged until mem_ack. Only one fetch is outstanding, and mem_req is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the configuration settings |
| cfg_pflim | input | 2 | Prefetch policy to load |
| cfg_bufen | input | 1 | Buffer enable to load |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_addr | input | 16 | Byte address of the read |
| rd_ready | output | 1 | One-cycle pulse: rd_data and rd_err are valid |
| rd_data | output | 32 | Read word |
| rd_err | output | 1 | The line fetch for this read failed |
| mem_req | output | 1 | Line fetch request |
| mem_addr | output | 12 | Line number being fetched |
| mem_ack | input | 1 | Fetch complete, mem_data and mem_err valid |
| mem_data | input | 128 | Returned line |
| mem_err | input | 1 | Returned line is bad |

## Verification
The bench runs reads in several patterns. First-touch reads separate hit service from miss service by latency and by the number of fetches. Repeated reads under each policy separate keeping a line from not keeping it and prefetching from not prefetching. Back-to-back reads issued while a fetch is in flight separate waiting on that fetch from issuing a duplicate. They also show whether the demand fetch or the queued prefetch is issued first. A sequence that fills all four buffers and then reads lines at both ends of the use order separates true LRU from other replacement choices. A behavioural model compares every cycle throughout.

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 128,
  parameter int NBUF = 4,
  localparam int LNW = AW - $clog2(LW/8)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_pflim,
  input  logic           cfg_bufen,
  input  logic           rd_req,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_ready,
  output logic [DW-1:0]  rd_data,
  output logic           rd_err,
  output logic           mem_req,
  output logic [LNW-1:0] mem_addr,
  input  logic           mem_ack,
  input  logic [LW-1:0]  mem_data,
  input  logic           mem_err
);
  localparam int OW   = $clog2(LW/8);
  localparam int WSEL = $clog2(LW/DW);
  localparam int RW   = $clog2(NBUF);

  typedef logic [NBUF-1:0][RW-1:0] rank_t;

  logic [1:0]            pfl_q;
  logic                  ben_q;
  logic [NBUF-1:0]       vld_q;
  logic [NBUF-1:0][LNW-1:0] tag_q;
  logic [NBUF-1:0][LW-1:0]  dat_q;
  rank_t                 rank_q, rank_a, rank_n;
  logic                  pend_q, f_fill;
  logic [LNW-1:0]        pend_line;

  logic [LNW-1:0]  req_line, next_line;
  logic [WSEL-1:0] req_word;
  logic            unused_lsb;
  assign req_line   = rd_addr[AW-1:OW];
  assign req_word   = rd_addr[OW-1 -: WSEL];
  assign next_line  = req_line + LNW'(1);
  assign unused_lsb = ^rd_addr[OW-WSEL-1:0];

  logic            hit, nxt_buf, pend_buf;
  logic [RW-1:0]   hit_idx, vic;
  logic            have_free;

  always_comb begin
    hit = 1'b0; hit_idx = '0; nxt_buf = 1'b0; pend_buf = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (ben_q && vld_q[i]) begin
        if (tag_q[i] == req_line) begin
          hit = 1'b1;
          hit_idx = RW'(i);
        end
        if (tag_q[i] == next_line) nxt_buf = 1'b1;
        if (tag_q[i] == pend_line) pend_buf = 1'b1;
      end
    end
  end

  logic active, ack, ack_serve, hit_serve, pf_want, miss_issue;
  logic pend_hit, pend_issue, do_fill;

  assign active     = rd_req && !rd_ready;
  assign ack        = mem_req && mem_ack;
  assign ack_serve  = ack && active && (req_line == mem_addr);
  assign hit_serve  = active && !ack_serve && hit;
  assign pf_want    = hit_serve && pfl_q[1] && !nxt_buf
                      && !(mem_req && mem_addr == next_line)
                      && !(pend_q && pend_line == next_line);
  assign miss_issue = active && !ack_serve && !hit && !mem_req;
  assign pend_hit   = pend_q && pend_buf;
  assign pend_issue = pend_q && !mem_req && !miss_issue && !pf_want && !pend_hit;
  assign do_fill    = ack && !mem_err && f_fill && ben_q;

  function automatic rank_t touch(input rank_t r, input logic [RW-1:0] k);
    rank_t o;
    for (int j = 0; j < NBUF; j++) begin
      if (j == int'(k))     o[j] = '0;
      else if (r[j] < r[k]) o[j] = r[j] + RW'(1);
      else                  o[j] = r[j];
    end
    return o;
  endfunction

  assign rank_a = hit_serve ? touch(rank_q, hit_idx) : rank_q;

  always_comb begin
    vic = '0; have_free = 1'b0;
    for (int i = NBUF-1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        vic = RW'(i);
        have_free = 1'b1;
      end
    end
    if (!have_free) begin
      for (int i = 0; i < NBUF; i++)
        if (rank_a[i] == RW'(NBUF-1)) vic = RW'(i);
    end
  end

  assign rank_n = do_fill ? touch(rank_a, vic) : rank_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfl_q    <= 2'b10;
      ben_q    <= 1'b1;
      rd_ready <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      if (cfg_wr) begin
        pfl_q <= cfg_pflim;
        ben_q <= cfg_bufen;
      end
      rd_ready <= ack_serve || hit_serve;
      rd_err   <= ack_serve && mem_err;
      if (ack_serve)      rd_data <= mem_data[req_word*DW +: DW];
      else if (hit_serve) rd_data <= dat_q[hit_idx][req_word*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      f_fill   <= 1'b0;
    end else if (ack) begin
      mem_req <= 1'b0;
    end else if (miss_issue) begin
      mem_req  <= 1'b1;
      mem_addr <= req_line;
      f_fill   <= (pfl_q != 2'b00);
    end else if (pf_want && !mem_req) begin
      mem_req  <= 1'b1;
      mem_addr <= next_line;
      f_fill   <= 1'b1;
    end else if (pend_issue) begin
      mem_req  <= 1'b1;
      mem_addr <= pend_line;
      f_fill   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_line <= '0;
    end else if (!ben_q) begin
      pend_q <= 1'b0;
    end else if (pf_want) begin
      pend_q    <= mem_req;
      pend_line <= next_line;
    end else if (pend_hit || pend_issue || (miss_issue && pend_line == req_line)) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NBUF; i++) rank_q[i] <= RW'(i);
    end else begin
      rank_q <= rank_n;
      if (!ben_q)       vld_q <= '0;
      else if (do_fill) vld_q[vic] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[vic] <= mem_addr;
      dat_q[vic] <= mem_data;
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

  a_r6_no_buffer_serve: assert property (@(posedge clk) disable iff (!rst_n)
    (!ben_q && rd_req && !rd_ready && !(mem_req && mem_ack)) |=> !rd_ready);

  a_r7_err_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> ($countones(vld_q) <= $past($countones(vld_q))));

  a_r7_err_only_from_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> ($past(mem_ack) && $past(mem_err)));
endmodule

// File: tb/test_flash_line_prefetch.sv
module test_flash_line_prefetch;
  localparam int LAT = 3;
  localparam int ERR_LINE = 12'h0AB;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [1:0]   cfg_pflim = 2'b00;
  logic         cfg_bufen = 1'b1;
  logic         rd_req = 1'b0;
  logic [15:0]  rd_addr = '0;
  logic         rd_ready, rd_err;
  logic [31:0]  rd_data;
  logic         mem_req;
  logic [11:0]  mem_addr;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_data = '0;
  logic         mem_err = 1'b0;

  flash_line_prefetch i_flash_line_prefetch (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pflim(cfg_pflim), .cfg_bufen(cfg_bufen),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data), .mem_err(mem_err));

  always #5 clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0, fetch_cnt = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;
  int    flog[$];

  function automatic logic [31:0] wordof(input int line, input int w);
    return {8'hC3, 4'(w), 12'(line), 8'(line*3 + w)};
  endfunction

  task automatic chk(input string tag, input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // array responder
  int mcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mcnt = 0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt >= LAT) begin
        mem_ack = 1'b1;
        for (int w = 0; w < 4; w++) mem_data[32*w +: 32] = wordof(int'(mem_addr), w);
        mem_err = (int'(mem_addr) == ERR_LINE);
      end
    end
  end

  // behavioural reference: timestamps for use order, line numbers for contents
  int m_pfl, m_time, m_fline, m_pline;
  bit m_ben, m_busy, m_ffill, m_pend;
  bit m_vld[4];
  int m_tag[4];
  int m_ts[4];
  bit e_ready, e_err;
  logic [31:0] e_data;

  function automatic bit m_has(input int x);
    for (int i = 0; i < 4; i++) if (m_ben && m_vld[i] && m_tag[i] == x) return 1'b1;
    return 1'b0;
  endfunction

  bit p_req, p_ack, hs_bad;
  int p_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pfl = 2; m_ben = 1; m_busy = 0; m_pend = 0; m_time = 1; m_fline = 0; m_pline = 0; m_ffill = 0;
      for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_ts[i] = -1 - i; end
      e_ready = 0; e_err = 0; e_data = '0;
      p_req = 0; p_ack = 0; p_addr = 0;
    end else begin
      // R11 handshake observed at the ports
      if (p_req && !p_ack && !(mem_req && int'(mem_addr) == p_addr)) hs_bad = 1'b1;
      p_req = mem_req; p_ack = mem_ack; p_addr = int'(mem_addr);
      if (mem_req && mem_ack) begin fetch_cnt++; flog.push_back(int'(mem_addr)); end
      begin
        bit act, ack, aserve, hserve, pfw, missi, pendhit, pendi, dofill;
        int line, w, nxt, hidx, vic, best;
        line = int'(rd_addr[15:4]); w = int'(rd_addr[3:2]); nxt = (line + 1) & 12'hFFF;
        act = rd_req && !e_ready;
        hidx = -1;
        for (int i = 0; i < 4; i++) if (m_ben && m_vld[i] && m_tag[i] == line) hidx = i;
        ack = m_busy && mem_ack;
        aserve = ack && act && (line == m_fline);
        hserve = act && !aserve && (hidx >= 0);
        pfw = hserve && (m_pfl >= 2) && !m_has(nxt) && !(m_busy && m_fline == nxt) && !(m_pend && m_pline == nxt);
        missi = act && !aserve && (hidx < 0) && !m_busy;
        pendhit = m_pend && m_has(m_pline);
        pendi = m_pend && !m_busy && !missi && !pfw && !pendhit;
        dofill = ack && !mem_err && m_ffill && m_ben;
        e_ready = aserve || hserve;
        e_err = aserve && mem_err;
        if (aserve) e_data = wordof(m_fline, w);
        else if (hserve) e_data = wordof(line, w);
        if (hserve) m_ts[hidx] = 2*m_time;
        if (dofill) begin
          vic = -1;
          for (int i = 3; i >= 0; i--) if (!m_vld[i]) vic = i;
          if (vic < 0) begin
            best = m_ts[0]; vic = 0;
            for (int i = 1; i < 4; i++) if (m_ts[i] < best) begin best = m_ts[i]; vic = i; end
          end
          m_vld[vic] = 1; m_tag[vic] = m_fline; m_ts[vic] = 2*m_time + 1;
        end
        if (!m_ben) for (int i = 0; i < 4; i++) m_vld[i] = 0;
        if (!m_ben) m_pend = 0;
        else if (pfw) begin m_pend = m_busy; m_pline = nxt; end
        else if (m_pend && (pendhit || pendi || (missi && m_pline == line))) m_pend = 0;
        if (ack) m_busy = 0;
        else if (missi) begin m_busy = 1; m_fline = line; m_ffill = (m_pfl != 0); end
        else if (pfw && !m_busy) begin m_busy = 1; m_fline = nxt; m_ffill = 1; end
        else if (pendi) begin m_busy = 1; m_fline = m_pline; m_ffill = 1; end
        if (cfg_wr) begin m_pfl = int'(cfg_pflim); m_ben = cfg_bufen; end
        m_time++;
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ok;
      ok = (rd_ready == e_ready) && (rd_err == e_err) && (rd_data == e_data)
           && (mem_req == m_busy) && (!m_busy || int'(mem_addr) == m_fline);
      n_chk++;
      if (!ok) begin
        n_bad++;
        $display("FAIL %s model mismatch: ready/err/data/req/addr actual=%0b/%0b/%h/%0b/%h expected=%0b/%0b/%h/%0b/%h",
                 cur_tag, rd_ready, rd_err, rd_data, mem_req, mem_addr, e_ready, e_err, e_data, m_busy, m_fline[11:0]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL %s watchdog expired actual=%0d expected<150000", cur_tag, cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic rd(input logic [15:0] a, output int lat, output logic [31:0] d, output logic e);
    rd_req = 1'b1; rd_addr = a; lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (rd_ready) break;
      if (lat > 300) break;
    end
    d = rd_data; e = rd_err;
    rd_req = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] p, input logic b);
    cfg_wr = 1'b1; cfg_pflim = p; cfg_bufen = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  initial begin
    int lat, f0;
    logic [31:0] d;
    logic e;
    hs_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rd_ready == 0 && rd_err == 0, "ready/err after reset", {rd_ready, rd_err}, 0);
    chk("R1", mem_req == 0, "mem_req after reset", mem_req, 0);

    // default policy (reset value 2'b10)
    cur_tag = "R2"; f0 = fetch_cnt;
    rd(16'h0104, lat, d, e);
    chk("R1", lat > 1, "first read must miss (latency)", lat, 2);
    chk("R2", d == wordof(12'h010, 1) && !e, "miss data", d, wordof(12'h010, 1));
    settle();
    chk("R5", fetch_cnt - f0 == 1, "fetches for one miss", fetch_cnt - f0, 1);
    cur_tag = "R4"; f0 = fetch_cnt;
    rd(16'h0108, lat, d, e);
    chk("R2", lat == 1, "hit latency", lat, 1);
    chk("R2", d == wordof(12'h010, 2), "hit data word 2", d, wordof(12'h010, 2));
    settle();
    chk("R1", fetch_cnt - f0 == 1, "reset policy prefetches on hit", fetch_cnt - f0, 1);
    chk("R4", flog[flog.size()-1] == 12'h011, "prefetched line", flog[flog.size()-1], 12'h011);
    rd(16'h0110, lat, d, e);
    chk("R4", lat == 1 && d == wordof(12'h011, 0), "prefetched line served as hit", lat, 1);
    settle();
    f0 = fetch_cnt;
    rd(16'h0104, lat, d, e);
    settle();
    chk("R4", lat == 1 && fetch_cnt == f0, "no prefetch when next line buffered", fetch_cnt - f0, 0);
    cur_tag = "R5"; f0 = fetch_cnt;
    rd(16'h0300, lat, d, e);
    settle();
    chk("R5", fetch_cnt - f0 == 1, "miss launches no prefetch", fetch_cnt - f0, 1);

    // LRU under policy 01
    cur_tag = "R10";
    cfg(2'b01, 1'b1);
    rd(16'h0400, lat, d, e); settle();
    rd(16'h0120, lat, d, e);
    chk("R10", lat == 1, "recently used line 012 kept", lat, 1);
    settle();
    rd(16'h0110, lat, d, e);
    chk("R10", lat > 1, "least recently used line 011 evicted", lat, 2);
    settle();
    rd(16'h0300, lat, d, e);
    chk("R10", lat == 1, "line 030 kept", lat, 1);
    settle();

    // policy 00
    cur_tag = "R3";
    cfg(2'b00, 1'b1);
    f0 = fetch_cnt;
    rd(16'h0500, lat, d, e); settle();
    rd(16'h0500, lat, d, e); settle();
    chk("R3", lat > 1, "policy 00 does not keep line", lat, 2);
    chk("R3", fetch_cnt - f0 == 2 && d == wordof(12'h050, 0), "refetch count", fetch_cnt - f0, 2);

    // policy 01
    cur_tag = "R2";
    cfg(2'b01, 1'b1);
    f0 = fetch_cnt;
    rd(16'h0600, lat, d, e); settle();
    rd(16'h0604, lat, d, e); settle();
    chk("R2", lat == 1 && d == wordof(12'h060, 1), "policy 01 keeps line", d, wordof(12'h060, 1));
    chk("R2", fetch_cnt - f0 == 1, "policy 01 no prefetch on hit", fetch_cnt - f0, 1);

    // error fetch
    cur_tag = "R7"; f0 = fetch_cnt;
    rd(16'h0AB0, lat, d, e); settle();
    chk("R7", e == 1'b1, "error flag to reader", e, 1);
    rd(16'h0AB4, lat, d, e); settle();
    chk("R7", e == 1'b1 && lat > 1 && fetch_cnt - f0 == 2, "failed line not kept", fetch_cnt - f0, 2);

    // enable off wipes
    cur_tag = "R6";
    cfg(2'b01, 1'b0);
    rd(16'h0600, lat, d, e); settle();
    chk("R6", lat > 1 && d == wordof(12'h060, 0), "no hit while disabled", lat, 2);
    cfg(2'b01, 1'b1);
    rd(16'h0600, lat, d, e); settle();
    chk("R6", lat > 1, "valid wiped by disable", lat, 2);
    rd(16'h0604, lat, d, e); settle();
    chk("R6", lat == 1, "refilled after enable", lat, 1);

    // read of line in flight
    cur_tag = "R8";
    cfg(2'b10, 1'b1);
    rd(16'h0700, lat, d, e); settle();
    f0 = fetch_cnt;
    rd(16'h0704, lat, d, e);
    rd(16'h0714, lat, d, e);
    settle();
    chk("R8", d == wordof(12'h071, 1), "served from in-flight prefetch", d, wordof(12'h071, 1));
    chk("R8", fetch_cnt - f0 == 1, "no duplicate fetch", fetch_cnt - f0, 1);

    // demand before queued prefetch
    cur_tag = "R9";
    rd(16'h0800, lat, d, e); settle();
    rd(16'h0900, lat, d, e); settle();
    flog.delete();
    rd(16'h0800, lat, d, e);
    rd(16'h0900, lat, d, e);
    rd(16'h0A00, lat, d, e);
    settle();
    chk("R9", flog.size() == 3, "fetch count", flog.size(), 3);
    if (flog.size() == 3) begin
      chk("R9", flog[0] == 12'h081, "first fetch is prefetch 081", flog[0], 12'h081);
      chk("R9", flog[1] == 12'h0A0, "demand 0A0 before queued prefetch", flog[1], 12'h0A0);
      chk("R9", flog[2] == 12'h091, "queued prefetch last", flog[2], 12'h091);
    end
    chk("R9", d == wordof(12'h0A0, 0), "demand data", d, wordof(12'h0A0, 0));

    chk("R11", hs_bad == 1'b0, "request held until acknowledge", hs_bad, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule